// File: doc/BRIEF.md
# EDO DRAM Refresh and Access Controller

This controller drives the strobe, write-enable, output-enable and multiplexed address pins of an asynchronous EDO DRAM with 4096 rows. It has a clocked host side. Single-word reads and writes arrive over a valid/ready handshake, and read results come back as a one-cycle data pulse. Every DRAM timing figure is a clock-cycle count. The 100 µs power-up pause and the 15.6 µs refresh spacing are worked out from the clock frequency parameter.

After reset the controller stays silent for the power-up pause. It then runs a wake-up burst of eight CAS-before-RAS refresh cycles, with write-enable held high, before it takes any request. After that it keeps a refresh debt counter and adds one to it each refresh interval. A pending refresh wins over host traffic, but only between host cycles. A pause input can hold off refresh. If the debt reaches its limit while refresh is held off, the controller blocks the host and repeats the eight-cycle wake-up burst once the pause ends.

Host cycles have a fixed order: row strobe, column strobe, precharge. Writes always use the early-write form, so the device keeps its outputs open during the write. Reads enable the device outputs only while the column strobe is low. Both strobes then go high for the precharge time, and this clears the EDO output latch.

Top module: `edo_ctrl`

## Requirements
- R1: For the first 100·CLK_MHZ cycles after reset, ras_n and cas_n stay high and req_ready stays low.
- R2: After the pause, exactly WAKE_CYCLES (8) refresh cycles complete before req_ready first goes high. wake_pend is high until they finish, and no row is opened for the host before then.
- R3: A refresh is CAS-before-RAS: cas_n falls while ras_n is high, ras_n then falls with cas_n still low, and we_n stays high throughout.
- R4: One refresh is issued for every 156·CLK_MHZ/10 cycles, on average over a long window. A refresh is started only from idle, never inside a host cycle, and it still gets through under back-to-back host traffic.
- R5: While ref_pause is high, no refresh starts. The refresh debt saturates at MAX_DEBT, and when it gets there wake_pend rises and req_ready drops. After ref_pause falls, eight refreshes run before req_ready returns.
- R6: A write (req_we=1) drives we_n low from the cycle ras_n falls, so we_n is low in the cycle before cas_n falls. Data is driven on dq_out with dq_oe=1, and oe_n stays high for the whole cycle.
- R7: A read (req_we=0) drives oe_n low only while cas_n is low. dq_in is captured T_CAC cycles after cas_n falls, and rd_valid pulses for one cycle T_RCD+T_CAC cycles after the accepting edge, with the stored word on rd_data.
- R8: After every cycle, ras_n and cas_n both stay high for at least T_RP cycles before either falls again.
- R9: The row address is req_addr[ROW_W+COL_W-1:COL_W], placed on dram_addr while ras_n falls. The column address is req_addr[COL_W-1:0], zero-extended on dram_addr while cas_n falls.
- R10: A request is accepted on an edge where req_valid and req_ready are both high, and req_ready stays low from then until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address: row bits above column bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse with read data |
| rd_data | output | DATA_W | Read data |
| ref_pause | input | 1 | Hold off refresh while high |
| wake_pend | output | 1 | Wake-up refresh burst outstanding |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dq_out | output | DATA_W | Data driven to the DRAM |
| dq_oe | output | 1 | Drive dq_out onto the data bus |
| dq_in | input | DATA_W | Data returned by the DRAM |

## Verification
Several rules are checked on every cycle: the silent power-up window, the write-enable level at each CAS-before-RAS row strobe, write-enable being low before the column strobe of a write, no bus contention between dq_oe and oe_n, the precharge hold after each strobe rises, no refresh starting under ref_pause, and no host row during a wake-up burst. Other behaviour only shows across whole scenarios. Those cover the count of wake-up refreshes, the average refresh rate over long idle and busy windows, debt saturation and the repeat wake-up after a long pause, and the correct row/column split as seen by a DRAM model. Read data and read latency are compared against a scoreboard fed by the request driver.

// File: rtl/edo_ctrl.sv
module edo_ctrl #(
  parameter int CLK_MHZ     = 100,
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int DATA_W      = 16,
  parameter int T_RCD       = 2,
  parameter int T_CAC       = 2,
  parameter int T_RP        = 2,
  parameter int T_CSR       = 1,
  parameter int T_RAS       = 3,
  parameter int WAKE_CYCLES = 8,
  parameter int MAX_DEBT    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  output logic                   rd_valid,
  output logic [DATA_W-1:0]      rd_data,
  input  logic                   ref_pause,
  output logic                   wake_pend,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   oe_n,
  output logic [ROW_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dq_out,
  output logic                   dq_oe,
  input  logic [DATA_W-1:0]      dq_in
);
  localparam int PWRUP_CYC = 100 * CLK_MHZ;
  localparam int REF_CYC   = (156 * CLK_MHZ) / 10;
  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int CNT_W     = $clog2(PWRUP_CYC + 1);
  localparam int TMR_W     = $clog2(REF_CYC + 1);
  localparam int DEBT_W    = $clog2(MAX_DEBT + 1);
  localparam int WK_W      = $clog2(WAKE_CYCLES + 1);

  typedef enum logic [2:0] {S_PWR, S_IDLE, S_ROW, S_COL, S_CBR_CAS, S_CBR_RAS, S_PRE} st_t;

  st_t               state;
  logic [CNT_W-1:0]  cnt;
  logic [TMR_W-1:0]  tmr;
  logic [DEBT_W-1:0] debt, debt_nx;
  logic [WK_W-1:0]   wk_cnt;
  logic [COL_W-1:0]  col_q;
  logic              op_wr, op_ref;

  wire tick     = (state != S_PWR) && (tmr == TMR_W'(REF_CYC - 1));
  wire ref_due  = !ref_pause && (wake_pend || debt != '0);
  wire done_ref = (state == S_PRE) && (cnt == '0) && op_ref;
  wire accept   = req_valid && req_ready;

  assign req_ready = (state == S_IDLE) && !wake_pend && !ref_due;

  always_ff @(posedge clk)
    if (!rst_n)        tmr <= '0;
    else if (state != S_PWR) tmr <= tick ? '0 : tmr + 1'b1;

  always_comb begin
    debt_nx = debt;
    if (done_ref && !wake_pend && debt != '0) debt_nx = debt_nx - 1'b1;
    if (tick && debt_nx != DEBT_W'(MAX_DEBT)) debt_nx = debt_nx + 1'b1;
  end

  always_ff @(posedge clk)
    if (!rst_n) begin
      debt      <= '0;
      wake_pend <= 1'b1;
      wk_cnt    <= '0;
    end else if (wake_pend) begin
      debt <= debt_nx;
      if (done_ref) begin
        if (wk_cnt == WK_W'(WAKE_CYCLES - 1)) begin
          wake_pend <= 1'b0;
          wk_cnt    <= '0;
          debt      <= '0;
        end else wk_cnt <= wk_cnt + 1'b1;
      end
    end else begin
      debt <= debt_nx;
      if (debt_nx == DEBT_W'(MAX_DEBT)) begin
        wake_pend <= 1'b1;
        wk_cnt    <= '0;
      end
    end

  always_ff @(posedge clk)
    if (!rst_n) begin
      state     <= S_PWR;
      cnt       <= CNT_W'(PWRUP_CYC - 1);
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dram_addr <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      col_q     <= '0;
      op_wr     <= 1'b0;
      op_ref    <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      if (cnt != '0) cnt <= cnt - 1'b1;
      case (state)
        S_PWR: if (cnt == '0) state <= S_IDLE;
        S_IDLE:
          if (ref_due) begin
            state  <= S_CBR_CAS;
            cas_n  <= 1'b0;
            op_ref <= 1'b1;
            op_wr  <= 1'b0;
            cnt    <= CNT_W'(T_CSR - 1);
          end else if (accept) begin
            state     <= S_ROW;
            ras_n     <= 1'b0;
            dram_addr <= req_addr[ADDR_W-1:COL_W];
            col_q     <= req_addr[COL_W-1:0];
            we_n      <= !req_we;
            op_wr     <= req_we;
            op_ref    <= 1'b0;
            dq_out    <= req_wdata;
            dq_oe     <= req_we;
            cnt       <= CNT_W'(T_RCD - 1);
          end
        S_ROW:
          if (cnt == '0) begin
            state     <= S_COL;
            cas_n     <= 1'b0;
            dram_addr <= ROW_W'(col_q);
            oe_n      <= op_wr;
            cnt       <= CNT_W'(T_CAC - 1);
          end
        S_COL:
          if (cnt == '0) begin
            if (!op_wr) begin
              rd_data  <= dq_in;
              rd_valid <= 1'b1;
            end
            state <= S_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            we_n  <= 1'b1;
            oe_n  <= 1'b1;
            dq_oe <= 1'b0;
            cnt   <= CNT_W'(T_RP - 1);
          end
        S_CBR_CAS:
          if (cnt == '0) begin
            state <= S_CBR_RAS;
            ras_n <= 1'b0;
            cnt   <= CNT_W'(T_RAS - 1);
          end
        S_CBR_RAS:
          if (cnt == '0) begin
            state <= S_PRE;
            ras_n <= 1'b1;
            cas_n <= 1'b1;
            cnt   <= CNT_W'(T_RP - 1);
          end
        S_PRE:
          if (cnt == '0) begin
            state  <= S_IDLE;
            op_ref <= 1'b0;
          end
        default: state <= S_IDLE;
      endcase
    end

  a_r1_quiet_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWR) |-> (ras_n && cas_n && !req_ready));
  a_r2_no_host_in_wake: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && cas_n) |-> !wake_pend);
  a_r3_cbr_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !cas_n) |-> we_n);
  a_r5_no_ref_paused: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |-> !$past(ref_pause));
  a_r6_early_write: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> (!$past(we_n) && oe_n));
  a_r6_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);
  a_r7_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !$past(oe_n));
  a_r8_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |=> (ras_n && cas_n));
endmodule

// File: tb/test_edo_ctrl.sv
module test_edo_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_MHZ  = 10;
  localparam int ROW_W    = 12;
  localparam int COL_W    = 10;
  localparam int DATA_W   = 16;
  localparam int T_RCD    = 2;
  localparam int T_CAC    = 2;
  localparam int T_RP     = 2;
  localparam int MAX_DEBT = 4;
  localparam int PWRUP    = 100 * CLK_MHZ;
  localparam int REFC     = (156 * CLK_MHZ) / 10;
  localparam int AW       = ROW_W + COL_W;
  localparam int WDOG     = 150000;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_we = 0, ref_pause = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, wake_pend, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic [ROW_W-1:0] dram_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  edo_ctrl #(.CLK_MHZ(CLK_MHZ), .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RP(T_RP), .MAX_DEBT(MAX_DEBT)) i_edo_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_we, .req_addr, .req_wdata,
    .rd_valid, .rd_data, .ref_pause, .wake_pend, .ras_n, .cas_n, .we_n, .oe_n,
    .dram_addr, .dq_out, .dq_oe, .dq_in);

  int n_chk = 0, n_bad = 0;
  int cyc = 0, since_rst = 0;
  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) since_rst <= since_rst + 1;
    if (cyc == WDOG) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  // behavioural DRAM model
  logic [DATA_W-1:0] dmem [int];
  logic [DATA_W-1:0] rd_word = '0;
  logic [ROW_W-1:0] cur_row = '0;
  logic p_ras = 1, p_cas = 1, p_we = 1, cbr_armed = 0;
  int ref_cnt = 0, ras_hi = 0, cas_hi = 0;
  assign dq_in = (!ras_n && !cas_n && !oe_n) ? rd_word : 16'hDEAD;

  always @(negedge clk) if (rst_n) begin
    if (since_rst < PWRUP) check(ras_n && cas_n, "R1 strobe in pause", {ras_n, cas_n}, 2'b11);
    if (p_cas && !cas_n) begin
      check(cas_hi >= T_RP, "R8 cas precharge", cas_hi, T_RP);
      if (ras_n) begin
        cbr_armed = 1;
        check(we_n, "R3 we at cbr cas", we_n, 1);
      end else begin
        logic [COL_W-1:0] col;
        col = dram_addr[COL_W-1:0];
        check(dram_addr[ROW_W-1:COL_W] == '0, "R9 col zero-ext", dram_addr, col);
        if (!we_n) begin
          check(!p_we, "R6 we setup", p_we, 0);
          check(oe_n && dq_oe, "R6 oe/dq_oe", {oe_n, dq_oe}, 2'b11);
          dmem[int'({cur_row, col})] = dq_out;
        end else begin
          check(!oe_n && !dq_oe, "R7 oe in read", {oe_n, dq_oe}, 2'b00);
          rd_word = dmem.exists(int'({cur_row, col})) ? dmem[int'({cur_row, col})] : '0;
        end
      end
    end
    if (p_ras && !ras_n) begin
      check(ras_hi >= T_RP, "R8 ras precharge", ras_hi, T_RP);
      if (!cas_n) begin
        check(cbr_armed && we_n, "R3 cbr order", {cbr_armed, we_n}, 2'b11);
        ref_cnt++;
      end else begin
        cur_row = dram_addr;
        check(ref_cnt >= 8, "R2 host before wake", ref_cnt, 8);
      end
    end
    if (ras_n) cbr_armed = cbr_armed && !cas_n;
    ras_hi = ras_n ? ras_hi + 1 : 0;
    cas_hi = cas_n ? cas_hi + 1 : 0;
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  // scoreboard
  logic [DATA_W-1:0] sb_mem [int];
  logic [DATA_W-1:0] exp_d[$];
  int exp_c[$];
  always @(negedge clk) if (rst_n && rd_valid) begin
    if (exp_d.size() == 0) check(0, "R7 unexpected rd_valid", rd_data, 0);
    else begin
      logic [DATA_W-1:0] d;
      int c;
      d = exp_d.pop_front(); c = exp_c.pop_front();
      check(rd_data == d, "R7/R9 read data", rd_data, d);
      check(cyc == c, "R7 read latency", cyc, c);
    end
  end

  task automatic issue(input bit we, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    if (we) sb_mem[int'(a)] = d;
    else begin
      exp_d.push_back(sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : '0);
      exp_c.push_back(cyc + 1 + T_RCD + T_CAC);
    end
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R10 ready drops when busy", req_ready, 0);
  endtask

  initial begin
    int r0;
    repeat (3) @(negedge clk);
    check(ras_n && cas_n && we_n && oe_n, "R1 reset strobes", {ras_n, cas_n, we_n, oe_n}, 4'hF);
    check(!req_ready && wake_pend && !rd_valid, "R2 reset flags", {req_ready, wake_pend, rd_valid}, 3'b010);
    rst_n = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    check(since_rst >= PWRUP, "R1 pause length", since_rst, PWRUP);
    check(ref_cnt == 8, "R2 wake count", ref_cnt, 8);
    check(!wake_pend, "R2 wake_pend cleared", wake_pend, 0);

    issue(1, 22'h000000, 16'h1234);
    issue(1, 22'h3FFFFF, 16'hFFFF);
    issue(1, 22'h3FF000, 16'hA5A5);
    issue(1, 22'h0003FF, 16'h5A5A);
    issue(1, 22'h155155, 16'h0F0F);
    issue(0, 22'h0003FF, 0);
    issue(0, 22'h3FF000, 0);
    issue(0, 22'h000000, 0);
    issue(0, 22'h3FFFFF, 0);
    issue(1, 22'h000000, 16'hBEEF);
    issue(0, 22'h000000, 0);
    issue(0, 22'h155155, 0);
    issue(0, 22'h2AA2AA, 0);

    r0 = ref_cnt;
    repeat (10 * REFC) @(negedge clk);
    check(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R4 idle refresh rate", ref_cnt - r0, 10);

    r0 = ref_cnt;
    for (int i = 0; i < 120; i++) issue(i[0], AW'(i * 37), DATA_W'(i * 91));
    check(ref_cnt - r0 >= 3, "R4 refresh under traffic", ref_cnt - r0, 3);

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ref_pause = 1;
    issue(1, 22'h0ABCDE, 16'hC0DE);
    issue(0, 22'h0ABCDE, 0);
    repeat (20) @(negedge clk);
    r0 = ref_cnt;
    repeat ((MAX_DEBT + 1) * REFC) @(negedge clk);
    check(ref_cnt == r0, "R5 no refresh paused", ref_cnt, r0);
    check(wake_pend && !req_ready, "R5 saturation blocks host", {wake_pend, req_ready}, 2'b10);
    ref_pause = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    check(ref_cnt - r0 == 8, "R5 repeat wake count", ref_cnt - r0, 8);
    issue(0, 22'h0ABCDE, 0);
    issue(0, 22'h3FFFFF, 0);

    repeat (20) @(negedge clk);
    check(exp_d.size() == 0, "R7 all reads returned", exp_d.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule